// File: doc/BRIEF.md
# DES Engine Register Guard and Error Interrupt

This block polices the register accesses made to a DES / Triple-DES cipher unit. It sits beside the cipher's register file. It watches every write and read on a simple single-cycle register bus and raises sticky error flags when software does something the cipher cannot honour. Such accesses include a key with a bad parity byte, an unsupported key or data length, a mode word with reserved bits set, changing cipher context while the cipher is working, and reading the IV before it is final. An error input from the cipher datapath is also captured. The datapath itself is not part of this block; a `busy` input stands in for it.

A mask register chooses which error kinds are reported. A masked kind never shows in the status register. The interrupt output is raised whenever any status flag is set. Software reads the status, then clears flags by writing ones to them.

Register map (4-bit address, one access per cycle): 0 mode, 1 key length, 2 data length, 3 IV, 4 key A, 5 key B, 6 key C, 7 mask, 8 status. Reads return the mode at address 0, the mask at address 7 and the status at address 8. Every other address reads zero.

Error bit layout, shared by mask and status (bits above 6 read zero): bit 6 key parity, bit 5 internal, bit 4 early IV read, bit 3 context change, bit 2 key length, bit 1 data length, bit 0 mode.

Top module: `des_guard`

## Requirements
- R1: Writing key A (address 4) with any byte whose eight bits hold an even number of ones sets status bit 6; if every byte has odd parity, the write sets nothing.
- R2: Writes to key B (5) and key C (6) are parity-checked as in R1 only while mode bit 2 (triple-key) is 1; with mode bit 2 at 0 they never set bit 6.
- R3: Writing the key length register (1) with a value other than 8, 16 or 24 sets status bit 2.
- R4: Writing the data length register (2) with a value that is not a multiple of 64 sets status bit 1, unless mode bits [1:0] are 11 (output-feedback chaining), when any value is accepted; 00, 01 and 10 select the other chainings.
- R5: Writing the mode register (0) with any bit above bit 2 set sets status bit 0; bits [2:0] of the written value are stored and read back at address 0 whether or not the value was legal.
- R6: Any write to addresses 0 to 6 while `busy` is 1 sets status bit 3, in addition to any error that the written value raises itself.
- R7: A read of the IV (address 3) while `busy` is 1 sets status bit 4; the same read while idle sets nothing.
- R8: A cycle with `int_err` at 1 sets status bit 5.
- R9: Status bits are sticky; writing the status register (8) clears each bit written as 1. An error raised in the same cycle wins over the clear.
- R10: A mask bit of 1 keeps the matching status bit at zero, including clearing it at once if it was already set; a mask bit of 0 lets the error through. The mask reads back at address 7.
- R11: `irq` is 1 exactly when any status bit is 1.
- R12: After reset the status, mask and mode read zero and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 64 | Write data |
| busy | input | 1 | Cipher is processing |
| int_err | input | 1 | Internal error pulse from the cipher datapath |
| rdata | output | 64 | Read data for the addressed register (combinational) |
| irq | output | 1 | Error interrupt, high while any status bit is set |

## Verification
The assertions take for granted that the bus carries at most one access per cycle. They assume a write and a read never share a cycle, and that the mask is not rewritten in the cycle an error they track is raised. The bench's stimulus keeps to this because every operation drives exactly one of write, read or `int_err`, for a single cycle, followed by an idle status read. Random keys are generated with correct parity and then corrupted in one byte on purpose. Lengths and mode words are drawn mostly from the legal sets, with a share of illegal values.

// File: rtl/des_guard_pkg.sv
package des_guard_pkg;

  localparam int DW     = 64;
  localparam int ADDR_W = 4;
  localparam int NREG   = 9;
  localparam int NERR   = 7;
  localparam int MODE_W = 3;

  // error bit positions (shared by mask and status)
  localparam int B_ME  = 0;
  localparam int B_DSE = 1;
  localparam int B_KSE = 2;
  localparam int B_CE  = 3;
  localparam int B_ERE = 4;
  localparam int B_IE  = 5;
  localparam int B_KPE = 6;

  // register addresses
  localparam int A_MODE  = 0;
  localparam int A_KLEN  = 1;
  localparam int A_DLEN  = 2;
  localparam int A_IV    = 3;
  localparam int A_KEYA  = 4;
  localparam int A_KEYB  = 5;
  localparam int A_KEYC  = 6;
  localparam int A_MASK  = 7;
  localparam int A_STAT  = 8;
  localparam int LAST_CTX = A_KEYC;

  localparam logic [1:0] CH_OFB = 2'b11;
  localparam int TRIPLE_BIT = 2;

  function automatic logic byte_is_odd(input logic [7:0] b);
    return ^b;
  endfunction

  function automatic logic klen_ok(input logic [DW-1:0] v);
    return (v == DW'(8)) || (v == DW'(16)) || (v == DW'(24));
  endfunction

  function automatic logic dlen_ok(input logic [DW-1:0] v, input logic [1:0] chain);
    return (chain == CH_OFB) || (v[5:0] == 6'd0);
  endfunction

  function automatic logic mode_ok(input logic [DW-1:0] v);
    return v[DW-1:MODE_W] == '0;
  endfunction

endpackage

// File: rtl/des_guard_decode.sv
module des_guard_decode
  import des_guard_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NR = NREG
) (
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output logic [NR-1:0] wr_sel,
  output logic          rd_iv
);
  for (genvar i = 0; i < NR; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (addr == AW'(i));
  end

  assign rd_iv = rd_en && (addr == AW'(A_IV));
endmodule

// File: rtl/des_guard_checks.sv
module des_guard_checks
  import des_guard_pkg::*;
#(
  parameter int W = DW,
  parameter int NE = NERR
) (
  input  logic [LAST_CTX:0] ctx_sel,
  input  logic              rd_iv,
  input  logic [W-1:0]      wdata,
  input  logic              busy,
  input  logic              int_err,
  input  logic [MODE_W-1:0] mode_q,
  output logic [NE-1:0]     ev
);
  localparam int NBYTES = W / 8;

  logic [NBYTES-1:0] byte_ok;
  for (genvar b = 0; b < NBYTES; b++) begin : g_par
    assign byte_ok[b] = byte_is_odd(wdata[b*8 +: 8]);
  end

  logic parity_good, check_extra, kpe_ev, kse_ev, dse_ev, me_ev, ce_ev;
  assign parity_good = &byte_ok;
  assign check_extra = (ctx_sel[A_KEYB] || ctx_sel[A_KEYC]) && mode_q[TRIPLE_BIT];
  assign kpe_ev = (ctx_sel[A_KEYA] || check_extra) && !parity_good;
  assign kse_ev = ctx_sel[A_KLEN] && !klen_ok(wdata);
  assign dse_ev = ctx_sel[A_DLEN] && !dlen_ok(wdata, mode_q[1:0]);
  assign me_ev  = ctx_sel[A_MODE] && !mode_ok(wdata);
  assign ce_ev  = busy && (|ctx_sel);

  always_comb begin
    ev        = '0;
    ev[B_KPE] = kpe_ev;
    ev[B_IE]  = int_err;
    ev[B_ERE] = busy && rd_iv;
    ev[B_CE]  = ce_ev;
    ev[B_KSE] = kse_ev;
    ev[B_DSE] = dse_ev;
    ev[B_ME]  = me_ev;
  end
endmodule

// File: rtl/des_guard_regs.sv
module des_guard_regs
  import des_guard_pkg::*;
#(
  parameter int NE = NERR,
  parameter logic [NE-1:0] MASK_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic              wr_mask,
  input  logic              wr_stat,
  input  logic [NE-1:0]     wlow,
  input  logic [NE-1:0]     ev,
  output logic [MODE_W-1:0] mode_q,
  output logic [NE-1:0]     mask_q,
  output logic [NE-1:0]     status_q
);
  logic [NE-1:0] mask_d, clr, status_d;

  assign mask_d   = wr_mask ? wlow : mask_q;
  assign clr      = wr_stat ? wlow : '0;
  assign status_d = ((status_q & ~clr) | ev) & ~mask_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      mask_q   <= MASK_RST;
      status_q <= '0;
    end else begin
      if (wr_mode) mode_q <= wlow[MODE_W-1:0];
      mask_q   <= mask_d;
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/des_guard.sv
module des_guard
  import des_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              busy,
  input  logic              int_err,
  output logic [DW-1:0]     rdata,
  output logic              irq
);
  logic [NREG-1:0]   wr_sel;
  logic              rd_iv;
  logic [NERR-1:0]   ev;
  logic [MODE_W-1:0] mode_q;
  logic [NERR-1:0]   mask_q;
  logic [NERR-1:0]   status_q;

  des_guard_decode #(.AW(ADDR_W), .NR(NREG)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_sel(wr_sel), .rd_iv(rd_iv)
  );

  des_guard_checks #(.W(DW), .NE(NERR)) u_chk_ev (
    .ctx_sel(wr_sel[LAST_CTX:0]), .rd_iv(rd_iv), .wdata(wdata), .busy(busy),
    .int_err(int_err), .mode_q(mode_q), .ev(ev)
  );

  des_guard_regs #(.NE(NERR)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_mode(wr_sel[A_MODE]), .wr_mask(wr_sel[A_MASK]), .wr_stat(wr_sel[A_STAT]),
    .wlow(wdata[NERR-1:0]), .ev(ev),
    .mode_q(mode_q), .mask_q(mask_q), .status_q(status_q)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(A_MODE): rdata = DW'(mode_q);
      ADDR_W'(A_MASK): rdata = DW'(mask_q);
      ADDR_W'(A_STAT): rdata = DW'(status_q);
      default:         rdata = '0;
    endcase
  end

  assign irq = |status_q;
endmodule

// File: rtl/des_guard_chk.sv
module des_guard_chk
  import des_guard_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              int_err,
  input logic [NERR-1:0]   mask_q,
  input logic [NERR-1:0]   status_q,
  input logic              irq
);
  logic ctx_wr, mask_wr;
  assign ctx_wr  = wr_en && (addr <= ADDR_W'(LAST_CTX));
  assign mask_wr = wr_en && (addr == ADDR_W'(A_MASK));

  assert_masked_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & mask_q) == '0);

  assert_irq_any_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (status_q != '0));

  assert_ctx_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_wr && busy && !mask_q[B_CE]) |=> status_q[B_CE]);

  assert_ce_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[B_CE]) |-> $past(ctx_wr && busy));

  assert_early_iv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && busy && addr == ADDR_W'(A_IV) && !mask_q[B_ERE]) |=> status_q[B_ERE]);

  assert_int_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_err && !mask_wr && !mask_q[B_IE]) |=> status_q[B_IE]);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

bind des_guard des_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .busy(busy), .int_err(int_err), .mask_q(mask_q), .status_q(status_q), .irq(irq)
);

// File: tb/des_guard_tb.sv
`timescale 1ns/1ps
module des_guard_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, wr_en, rd_en, busy, int_err, irq;
  logic [3:0]  addr;
  logic [63:0] wdata, rdata;

  des_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .busy(busy), .int_err(int_err), .rdata(rdata), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [6:0] m_st = '0, m_mask = '0;
  logic [2:0] m_mode = '0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected error flags: bit6 parity, 5 internal, 4 early IV, 3 context, 2 klen, 1 dlen, 0 mode
  function automatic logic [6:0] exp_ev(bit w, bit r, bit ie, int a, logic [63:0] d,
                                        bit b, logic [2:0] md);
    logic [6:0] e = '0;
    bit bad = 0;
    for (int i = 0; i < 8; i++) if ($countones(d[i*8 +: 8]) % 2 == 0) bad = 1;
    if (w) begin
      if (a == 4 && bad) e[6] = 1;
      if ((a == 5 || a == 6) && md[2] && bad) e[6] = 1;
      if (a == 1 && !(d == 8 || d == 16 || d == 24)) e[2] = 1;
      if (a == 2 && md[1:0] != 2'b11 && (d % 64) != 0) e[1] = 1;
      if (a == 0 && (d >> 3) != 0) e[0] = 1;
      if (b && a <= 6) e[3] = 1;
    end
    if (r && a == 3 && b) e[4] = 1;
    if (ie) e[5] = 1;
    return e;
  endfunction

  function automatic logic [63:0] make_key(bit good);
    logic [63:0] k;
    for (int i = 0; i < 8; i++) begin
      logic [6:0] v = 7'($urandom);
      k[i*8 +: 8] = {v, ~(^v)};
    end
    if (!good) k[($urandom % 8) * 8 + ($urandom % 8)] ^= 1'b1;
    return k;
  endfunction

  task automatic op(input string tag, input bit w, input bit r, input bit ie,
                    input int a, input logic [63:0] d, input bit b);
    logic [6:0] e, clr, mnew;
    @(negedge clk);
    wr_en = w; rd_en = r; int_err = ie; addr = a[3:0]; wdata = d; busy = b;
    e    = exp_ev(w, r, ie, a, d, b, m_mode);
    clr  = (w && a == 8) ? d[6:0] : 7'd0;
    mnew = (w && a == 7) ? d[6:0] : m_mask;
    if (w && a == 0) m_mode = d[2:0];
    m_st   = ((m_st & ~clr) | e) & ~mnew;
    m_mask = mnew;
    @(negedge clk);
    wr_en = 0; rd_en = 0; int_err = 0; busy = 0; addr = 4'd8;
    #1;
    check(tag, rdata, {57'd0, m_st});
    check({tag, " irq R11"}, {63'd0, irq}, {63'd0, |m_st});
  endtask

  task automatic rdcheck(input string tag, input int a, input logic [63:0] exp);
    @(negedge clk);
    addr = a[3:0];
    #1;
    check(tag, rdata, exp);
    addr = 4'd8;
  endtask

  task automatic clear_all();
    op("clear R9", 1, 0, 0, 8, 64'h7f, 0);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; busy = 0; int_err = 0; addr = 4'd8; wdata = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R12 status", rdata, 64'd0);
    check("R12 irq", {63'd0, irq}, 64'd0);
    rdcheck("R12 mask", 7, 64'd0);
    rdcheck("R12 mode", 0, 64'd0);

    op("R1 good key", 1, 0, 0, 4, 64'h0101_0101_0101_0101, 0);
    op("R1 bad key", 1, 0, 0, 4, 64'h0101_0101_0103_0101, 0);
    clear_all();
    op("R2 single keyB", 1, 0, 0, 5, 64'h0303_0303_0303_0303, 0);
    op("R2 single keyC", 1, 0, 0, 6, 64'h0000_0000_0000_0000, 0);
    op("R5 triple mode", 1, 0, 0, 0, 64'h4, 0);
    op("R2 triple keyC", 1, 0, 0, 6, 64'h0101_0101_0101_0100, 0);
    clear_all();
    op("R3 klen 16", 1, 0, 0, 1, 64'd16, 0);
    op("R3 klen 24", 1, 0, 0, 1, 64'd24, 0);
    op("R3 klen 12", 1, 0, 0, 1, 64'd12, 0);
    clear_all();
    op("R4 cbc mode", 1, 0, 0, 0, 64'h1, 0);
    op("R4 dlen 128", 1, 0, 0, 2, 64'd128, 0);
    op("R4 dlen 100 cbc", 1, 0, 0, 2, 64'd100, 0);
    clear_all();
    op("R4 ofb mode", 1, 0, 0, 0, 64'h3, 0);
    op("R4 dlen 100 ofb", 1, 0, 0, 2, 64'd100, 0);
    op("R5 illegal mode", 1, 0, 0, 0, 64'h8, 0);
    rdcheck("R5 readback low bits", 0, 64'd0);
    op("R5 mode 5", 1, 0, 0, 0, 64'h5, 0);
    rdcheck("R5 readback 5", 0, 64'd5);
    clear_all();
    op("R6 busy dlen ok", 1, 0, 0, 2, 64'd64, 1);
    op("R6 busy klen bad", 1, 0, 0, 1, 64'd5, 1);
    clear_all();
    op("R6 busy mask write", 1, 0, 0, 7, 64'h0, 1);
    op("R7 idle iv read", 0, 1, 0, 3, 64'd0, 0);
    op("R7 busy iv read", 0, 1, 0, 3, 64'd0, 1);
    op("R8 int err", 0, 0, 1, 0, 64'd0, 0);
    op("R9 sticky", 1, 0, 0, 1, 64'd8, 0);
    op("R9 clear one bit", 1, 0, 0, 8, 64'h10, 0);
    op("R9 set beats clear", 0, 0, 1, 0, 64'd0, 0);
    op("R10 mask internal", 1, 0, 0, 7, 64'h20, 0);
    rdcheck("R10 mask readback", 7, 64'h20);
    op("R10 masked int err", 0, 0, 1, 0, 64'd0, 0);
    op("R10 mask parity", 1, 0, 0, 7, 64'h40, 0);
    op("R10 masked bad key", 1, 0, 0, 4, 64'd0, 0);
    op("R10 unmask", 1, 0, 0, 7, 64'h0, 0);
    clear_all();

    for (int it = 0; it < 600; it++) begin
      int sel = $urandom % 10;
      bit b = ($urandom % 4) == 0;
      logic [63:0] d;
      case (sel)
        0: begin
          d = ($urandom % 8 == 0) ? {$urandom, $urandom} : 64'($urandom % 8);
          op("RAND mode", 1, 0, 0, 0, d, b);
        end
        1: begin
          case ($urandom % 4)
            0: d = 64'd8;
            1: d = 64'd16;
            2: d = 64'd24;
            default: d = 64'($urandom % 32);
          endcase
          op("RAND klen", 1, 0, 0, 1, d, b);
        end
        2: begin
          d = ($urandom % 4 == 0) ? 64'($urandom % 1000) : 64'(64 * ($urandom % 16));
          op("RAND dlen", 1, 0, 0, 2, d, b);
        end
        3: op("RAND iv write", 1, 0, 0, 3, {$urandom, $urandom}, b);
        4, 5, 6: op("RAND key", 1, 0, 0, sel, make_key(($urandom % 3) != 0), b);
        7: begin
          d = ($urandom % 2) ? 64'd0 : 64'($urandom % 128);
          op("RAND mask", 1, 0, 0, 7, d, b);
        end
        8: op("RAND status clear", 1, 0, 0, 8, 64'($urandom % 128), b);
        default: begin
          if ($urandom % 2) op("RAND iv read", 0, 1, 0, 3, 64'd0, b);
          else              op("RAND int err", 0, 0, 1, 0, 64'd0, b);
        end
      endcase
    end
    rdcheck("RAND mode readback", 0, {61'd0, m_mode});
    rdcheck("RAND mask readback", 7, {57'd0, m_mask});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule